// File: doc/BRIEF.md
# SPI Data Queue and Interrupt Block

This block sits between the register bus of a serial peripheral interface controller and its shift engine. It holds one queue of outgoing words and one queue of incoming words. It raises five interrupt sources and one combined line from the state of those queues.

Two of the sources follow the fill levels and clear themselves: one for an outgoing queue running low, one for an incoming queue filling up. The other three are sticky error flags: a write into a full outgoing queue, a push into a full incoming queue, and a read from an empty incoming queue. Each error flag stays set until software reads the clear register that belongs to it. Each source has its own enable bit, and the individual and combined outputs are active-high levels.

The shift engine takes outgoing words over a valid/ready stream. `tx_out_valid` is high whenever the outgoing queue holds a word, and a word leaves on a cycle where both `tx_out_valid` and `tx_out_ready` are high. Incoming words arrive on a stream that has no back-pressure. A word is offered on any cycle with `rx_in_valid` high and is always consumed that cycle: it is stored if there is room and dropped if there is not. The register bus is single-cycle. `bus_rdata` is valid in the same cycle as `bus_rd`, and read side effects take place at the closing clock edge.

Top module: `spi_fifo_irq_ctrl`

Register offsets (bus_addr):
- 0: data. A write enqueues an outgoing word; a read dequeues an incoming word.
- 1: outgoing threshold.
- 2: incoming threshold.
- 3: enable mask.
- 4: raw sources.
- 5: enabled sources.
- 6: outgoing level.
- 7: incoming level.
- 8: clear outgoing-overflow.
- 9: clear incoming-overflow.
- 10: clear incoming-underflow.

Source bit order in the mask, raw and enabled registers:
- bit 0: outgoing low
- bit 1: outgoing overflow
- bit 2: incoming full
- bit 3: incoming overflow
- bit 4: incoming underflow

## Requirements
- R1: After reset both levels read 0, both thresholds are 0, the mask reads 0x1F, the raw register reads 0x01, and `irq_tx_empty` and `irq_any` are high.
- R2: Raw bit 0 (outgoing low) is high exactly when the outgoing level is less than or equal to the outgoing threshold. It follows the level with no further delay.
- R3: Raw bit 2 (incoming full) is high exactly when the incoming level is greater than or equal to the incoming threshold plus one.
- R4: A bus write to offset 0 while the outgoing queue holds DEPTH words and no word leaves that cycle is dropped, and it sets raw bit 1. That bit stays set until offset 8 is read.
- R5: A push on the incoming stream while the incoming queue is full and no bus read dequeues that cycle is dropped, and it sets raw bit 3. That bit stays set until offset 9 is read.
- R6: A bus read of offset 0 while the incoming queue is empty returns 0x00 and sets raw bit 4. That bit stays set until offset 10 is read.
- R7: A read of a clear register returns the flag's prior value in bit 0 and clears the flag at that edge. If a new error event for the same flag happens in that same cycle, the flag stays set.
- R8: Each individual interrupt output equals its raw source ANDed with its mask bit, and offset 5 reads raw AND mask.
- R9: `irq_any` is the OR of the five enabled sources, so it is low whenever the mask is 0.
- R10: An enqueue and a dequeue in the same cycle leave the level unchanged. When the queue is full, this case is accepted and flags no overflow.
- R11: Words leave each queue in the order they entered, and `tx_out_valid` is low when the outgoing queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid during bus_rd |
| tx_out_valid | output | 1 | Outgoing word available |
| tx_out_ready | input | 1 | Shift engine takes the outgoing word |
| tx_out_data | output | DW | Outgoing word at head of queue |
| rx_in_valid | input | 1 | Incoming word offered (no back-pressure) |
| rx_in_data | input | DW | Incoming word |
| irq_tx_empty | output | 1 | Outgoing-low interrupt, enabled |
| irq_tx_ovf | output | 1 | Outgoing-overflow interrupt, enabled |
| irq_rx_full | output | 1 | Incoming-full interrupt, enabled |
| irq_rx_ovf | output | 1 | Incoming-overflow interrupt, enabled |
| irq_rx_unf | output | 1 | Incoming-underflow interrupt, enabled |
| irq_any | output | 1 | OR of all enabled sources |

## Verification
Two collisions are provoked on purpose. In the first, a clear-register read lands in the same cycle as a fresh push into the full incoming queue. The read must return 1 and the flag must still read 1 afterwards, while a later clear read with no event must leave it at 0. In the second, an enqueue and a dequeue hit a full queue on both sides at once. There the level read back must stay at DEPTH and the overflow bits must stay low. The threshold rules are swept over every threshold and every fill level, and the expected states are computed arithmetically in the bench.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  typedef enum logic [3:0] {
    REG_DATA    = 4'd0,
    REG_TX_THR  = 4'd1,
    REG_RX_THR  = 4'd2,
    REG_MASK    = 4'd3,
    REG_RAW     = 4'd4,
    REG_MASKED  = 4'd5,
    REG_TX_LVL  = 4'd6,
    REG_RX_LVL  = 4'd7,
    REG_CLR_TXO = 4'd8,
    REG_CLR_RXO = 4'd9,
    REG_CLR_RXU = 4'd10
  } reg_addr_e;

  localparam int IRQ_N   = 5;
  localparam int IRQ_TXE = 0;
  localparam int IRQ_TXO = 1;
  localparam int IRQ_RXF = 2;
  localparam int IRQ_RXO = 3;
  localparam int IRQ_RXU = 4;

  localparam int ERR_N   = 3;

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic [DW-1:0]    head
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign rd_ok = pop & ~empty;
  assign wr_ok = push & (~full | rd_ok);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)) else $error("level above depth"); // R11

  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(level)) else $error("push+pop moved level"); // R10

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full) else $error("full queue changed on dropped push"); // R4

endmodule

// File: rtl/sfq_sticky.sv
module sfq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag) else $error("event lost"); // R7

  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag) else $error("flag dropped without clear"); // R6

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  input  logic [DW-1:0] rx_in_data,
  output logic          irq_tx_empty,
  output logic          irq_tx_ovf,
  output logic          irq_rx_full,
  output logic          irq_rx_ovf,
  output logic          irq_rx_unf,
  output logic          irq_any
);

  logic             wr_data, rd_data;
  logic             tx_wr_ok, tx_rd_ok, tx_full, tx_empty;
  logic             rx_wr_ok, rx_rd_ok, rx_full, rx_empty;
  logic [LVL_W-1:0] tx_lvl, rx_lvl;
  logic [DW-1:0]    tx_head, rx_head;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [IRQ_N-1:0] mask, raw, enabled;
  logic [ERR_N-1:0] err_set, err_clr, err_flag;

  assign wr_data = bus_wr & (bus_addr == REG_DATA);
  assign rd_data = bus_rd & (bus_addr == REG_DATA);

  sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(wr_data), .push_data(bus_wdata), .pop(tx_out_ready),
    .wr_ok(tx_wr_ok), .rd_ok(tx_rd_ok), .full(tx_full), .empty(tx_empty),
    .level(tx_lvl), .head(tx_head)
  );

  sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(rx_in_valid), .push_data(rx_in_data), .pop(rd_data),
    .wr_ok(rx_wr_ok), .rd_ok(rx_rd_ok), .full(rx_full), .empty(rx_empty),
    .level(rx_lvl), .head(rx_head)
  );

  assign tx_out_valid = ~tx_empty;
  assign tx_out_data  = tx_head;

  // error events: index 0 tx overflow, 1 rx overflow, 2 rx underflow
  assign err_set[0] = wr_data & ~tx_wr_ok;
  assign err_set[1] = rx_in_valid & ~rx_wr_ok;
  assign err_set[2] = rd_data & ~rx_rd_ok;
  assign err_clr[0] = bus_rd & (bus_addr == REG_CLR_TXO);
  assign err_clr[1] = bus_rd & (bus_addr == REG_CLR_RXO);
  assign err_clr[2] = bus_rd & (bus_addr == REG_CLR_RXU);

  for (genvar g = 0; g < ERR_N; g++) begin : g_err
    sfq_sticky u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(err_set[g]), .clr(err_clr[g]), .flag(err_flag[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
      mask   <= '1;
    end else if (bus_wr) begin
      if (bus_addr == REG_TX_THR) tx_thr <= bus_wdata[THR_W-1:0];
      if (bus_addr == REG_RX_THR) rx_thr <= bus_wdata[THR_W-1:0];
      if (bus_addr == REG_MASK)   mask   <= bus_wdata[IRQ_N-1:0];
    end
  end

  always_comb begin
    raw          = '0;
    raw[IRQ_TXE] = (tx_lvl <= LVL_W'(tx_thr));
    raw[IRQ_TXO] = err_flag[0];
    raw[IRQ_RXF] = (rx_lvl >= LVL_W'(rx_thr) + LVL_W'(1));
    raw[IRQ_RXO] = err_flag[1];
    raw[IRQ_RXU] = err_flag[2];
  end

  assign enabled      = raw & mask;
  assign irq_tx_empty = enabled[IRQ_TXE];
  assign irq_tx_ovf   = enabled[IRQ_TXO];
  assign irq_rx_full  = enabled[IRQ_RXF];
  assign irq_rx_ovf   = enabled[IRQ_RXO];
  assign irq_rx_unf   = enabled[IRQ_RXU];
  assign irq_any      = |enabled;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_DATA:    bus_rdata = rx_empty ? '0 : rx_head;
      REG_TX_THR:  bus_rdata = DW'(tx_thr);
      REG_RX_THR:  bus_rdata = DW'(rx_thr);
      REG_MASK:    bus_rdata = DW'(mask);
      REG_RAW:     bus_rdata = DW'(raw);
      REG_MASKED:  bus_rdata = DW'(enabled);
      REG_TX_LVL:  bus_rdata = DW'(tx_lvl);
      REG_RX_LVL:  bus_rdata = DW'(rx_lvl);
      REG_CLR_TXO: bus_rdata = DW'(err_flag[0]);
      REG_CLR_RXO: bus_rdata = DW'(err_flag[1]);
      REG_CLR_RXU: bus_rdata = DW'(err_flag[2]);
      default:     bus_rdata = '0;
    endcase
  end

  AST_TXO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_out_ready) |=> irq_tx_ovf || !mask[IRQ_TXO]) else $error("tx overflow missed"); // R4

  AST_RXO_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_full && !rd_data) |=> raw[IRQ_RXO]) else $error("rx overflow missed"); // R5

  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_empty) |-> (bus_rdata == '0)) else $error("underflow read not zero"); // R6

  AST_ANY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_any) else $error("combined line with all masked"); // R9

  AST_TXE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> mask[IRQ_TXE]) else $error("masked source leaked"); // R8

endmodule

// File: tb/sim_spi_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_fifo_irq_ctrl;

  localparam int DEPTH = 8;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          tx_out_valid, tx_out_ready = 1'b0;
  logic [DW-1:0] tx_out_data;
  logic          rx_in_valid = 1'b0;
  logic [DW-1:0] rx_in_data = '0;
  logic          irq_tx_empty, irq_tx_ovf, irq_rx_full, irq_rx_ovf, irq_rx_unf, irq_any;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .irq_tx_empty(irq_tx_empty), .irq_tx_ovf(irq_tx_ovf), .irq_rx_full(irq_rx_full),
    .irq_rx_ovf(irq_rx_ovf), .irq_rx_unf(irq_rx_unf), .irq_any(irq_any)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 4'(a); bus_rd = 1'b1;
    #1 d = int'(bus_rdata);
    step();
    bus_rd = 1'b0;
  endtask

  task automatic push_rx(input int d);
    rx_in_data = 8'(d); rx_in_valid = 1'b1;
    step();
    rx_in_valid = 1'b0;
  endtask

  task automatic pop_tx(output int d);
    tx_out_ready = 1'b1;
    #1 d = int'(tx_out_data);
    step();
    tx_out_ready = 1'b0;
  endtask

  function automatic int irq_vec();
    return {27'd0, irq_rx_unf, irq_rx_ovf, irq_rx_full, irq_tx_ovf, irq_tx_empty};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    do_reset();

    // R1 reset state
    rd(6, v); check("R1 tx level", v, 0);
    rd(7, v); check("R1 rx level", v, 0);
    rd(1, v); check("R1 tx thr", v, 0);
    rd(2, v); check("R1 rx thr", v, 0);
    rd(3, v); check("R1 mask", v, 8'h1F);
    rd(4, v); check("R1 raw", v, 1);
    check("R1 irq_tx_empty", int'(irq_tx_empty), 1);
    check("R1 irq_any", int'(irq_any), 1);
    check("R11 tx_out_valid empty", int'(tx_out_valid), 0);

    // R2 sweep every threshold and level, then R4 and R11 on the full queue
    for (int thr = 0; thr < DEPTH; thr++) begin
      do_reset();
      wr(1, thr);
      for (int k = 0; k <= DEPTH; k++) begin
        check("R2 tx low", int'(irq_tx_empty), (k <= thr) ? 1 : 0);
        rd(6, v); check("R2 tx level", v, k);
        if (k < DEPTH) wr(0, thr * 16 + k);
      end
      wr(0, 8'hEE);
      rd(6, v); check("R4 level held", v, DEPTH);
      check("R4 irq_tx_ovf", int'(irq_tx_ovf), 1);
      for (int k = 0; k < DEPTH; k++) begin
        check("R11 tx valid", int'(tx_out_valid), 1);
        pop_tx(v); check("R11 tx order", v, thr * 16 + k);
      end
      check("R4 extra word dropped", int'(tx_out_valid), 0);
      rd(4, v); check("R4 flag persists", (v >> 1) & 1, 1);
      rd(8, v); check("R7 clear returns prior", v, 1);
      rd(4, v); check("R7 flag cleared", (v >> 1) & 1, 0);
      rd(8, v); check("R7 second clear", v, 0);
    end

    // R3 sweep, then R5, R11 and R6 on the incoming queue
    for (int thr = 0; thr < DEPTH; thr++) begin
      do_reset();
      wr(2, thr);
      for (int k = 0; k <= DEPTH; k++) begin
        check("R3 rx full", int'(irq_rx_full), (k >= thr + 1) ? 1 : 0);
        if (k < DEPTH) push_rx(8'h80 + thr * 8 + k);
      end
      push_rx(8'h55);
      rd(7, v); check("R5 level held", v, DEPTH);
      check("R5 irq_rx_ovf", int'(irq_rx_ovf), 1);
      for (int k = 0; k < DEPTH; k++) begin
        rd(0, v); check("R11 rx order", v, 8'h80 + thr * 8 + k);
      end
      check("R5 flag persists", int'(irq_rx_ovf), 1);
      rd(9, v); check("R5 clear returns 1", v, 1);
      check("R5 cleared", int'(irq_rx_ovf), 0);
      check("R6 no underflow yet", int'(irq_rx_unf), 0);
      rd(0, v); check("R6 empty read zero", v, 0);
      check("R6 irq_rx_unf", int'(irq_rx_unf), 1);
      rd(10, v); check("R6 clear returns 1", v, 1);
      check("R6 cleared", int'(irq_rx_unf), 0);
    end

    // R8 R9: all five raw sources set, sweep every mask value
    do_reset();
    rd(0, v);
    for (int k = 0; k <= DEPTH; k++) push_rx(k);
    for (int k = 0; k <= DEPTH; k++) wr(0, k);
    for (int k = 0; k < DEPTH; k++) pop_tx(v);
    rd(4, v); check("R8 all raw set", v, 8'h1F);
    for (int m = 0; m < 32; m++) begin
      wr(3, m);
      check("R8 lines follow mask", irq_vec(), m);
      rd(5, v); check("R8 enabled reg", v, m);
      check("R9 combined", int'(irq_any), (m != 0) ? 1 : 0);
    end
    wr(3, 8'h1F);

    // R7: clear read colliding with a new rx overflow (rx queue is full)
    bus_addr = 4'd9; bus_rd = 1'b1; rx_in_valid = 1'b1; rx_in_data = 8'hAA;
    #1 v = int'(bus_rdata);
    step();
    bus_rd = 1'b0; rx_in_valid = 1'b0;
    check("R7 collide returns prior", v, 1);
    check("R7 event wins over clear", int'(irq_rx_ovf), 1);
    rd(9, v); check("R7 clear after collide", v, 1);
    check("R7 flag now low", int'(irq_rx_ovf), 0);

    // R10: full queues, enqueue and dequeue at once on both sides
    rd(8, v);
    for (int k = 0; k < DEPTH; k++) wr(0, 8'h40 + k);
    bus_addr = 4'd0; bus_wdata = 8'h4F; bus_wr = 1'b1; tx_out_ready = 1'b1;
    #1 v = int'(tx_out_data);
    step();
    bus_wr = 1'b0; tx_out_ready = 1'b0;
    check("R10 tx head popped", v, 8'h40);
    rd(6, v); check("R10 tx level kept", v, DEPTH);
    check("R10 no tx overflow", int'(irq_tx_ovf), 0);
    bus_addr = 4'd0; bus_rd = 1'b1; rx_in_valid = 1'b1; rx_in_data = 8'h99;
    #1 v = int'(bus_rdata);
    step();
    bus_rd = 1'b0; rx_in_valid = 1'b0;
    check("R10 rx head read", v, 0);
    rd(7, v); check("R10 rx level kept", v, DEPTH);
    check("R10 no rx overflow", int'(irq_rx_ovf), 0);
    for (int k = 1; k < DEPTH; k++) pop_tx(v);
    pop_tx(v); check("R10 tx tail word", v, 8'h4F);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule